// File: doc/BRIEF.md
# Prefix-extended halfword load unit

This block is the execute stage for a register-indirect 16-bit load in a small processor whose general registers are 24 bits wide. One 16-bit instruction word arrives per issue slot, along with a flag saying the word sits in the delay slot of a delayed branch. Up to two preceding displacement prefix words are held as pending state. When a load arrives, the unit adds the displacement they describe to a base register, issues a read on a synchronous memory port and, one cycle later, writes the returned halfword into an eight-entry register file with the upper byte cleared.

An odd effective address is not fatal. The read still takes place with address bit 0 forced low, and a one-cycle misalignment pulse is raised for the exception logic. A load in a delay slot ignores any pending prefix. Any other non-prefix word only discards the pending prefix state. A second read port lets the surrounding pipeline (and the bench) look at any register.

Top module: `hwld_unit`

## Requirements
- R1: A word is a load only when issue_vld is high, bits 15:10 equal 001000 and bits 6:3 equal 0010. Bits 9:7 then name the destination and bits 2:0 the base, r0 to r7. No other word, and no word with issue_vld low, asserts mem_rd_en.
- R2: The edge that ends the cycle after the load issues writes mem_rd_data into bits 15:0 of the destination and zero into bits 23:16.
- R3: With no pending prefix, the effective address equals the base register value.
- R4: A prefix word has bits 15:13 equal 110 and carries a 13-bit immediate in bits 12:0. With one pending prefix, the effective address is the base plus that immediate zero-extended, modulo 2^24.
- R5: With two pending prefixes, bits 10:0 of the older one form displacement bits 23:13 and the newer one forms bits 12:0. The sum with the base wraps modulo 2^24.
- R6: The load never changes its base register, unless that register is also the destination. All registers other than the destination keep their values.
- R7: When the effective address is odd, misalign_pulse is high for the one cycle after the load issues. The read still occurs, and mem_rd_addr never has bit 0 set.
- R8: A load issued with issue_in_slot high uses the plain base address, whatever prefixes are pending, and it clears them.
- R9: Pending prefixes are cleared by a load and by any valid non-prefix word, and they are held through cycles with issue_vld low. A third consecutive prefix displaces the oldest one.
- R10: mem_rd_en and mem_rd_addr are driven in the issue cycle itself, so one load completes per cycle. A load whose base is the previous load's destination sees that load's returned data.
- R11: After reset all registers read zero, no prefix is pending, and misalign_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An instruction word is issued this cycle |
| issue_word | input | 16 | Issued instruction word |
| issue_in_slot | input | 1 | Word sits in a delayed-branch slot |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 24 | Read address, bit 0 always zero |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| misalign_pulse | output | 1 | Odd effective address seen on the previous load |
| obs_sel | input | 3 | Register selected for observation |
| obs_data | output | 24 | Contents of the selected register |

## Verification
On every cycle the assertions check the following. Read addresses are even. A memory read is always followed by a writeback, and no writeback occurs without one. The misalignment pulse appears only alongside a writeback. A delay-slot load addresses exactly its base register. The prefix count stays at two or below, drops to zero after any valid non-prefix word and holds while nothing issues. Only the bench's scenarios can show that the arithmetic values are right: the 13-bit and 24-bit displacement sums with wrap-around, a third prefix displacing the oldest, forwarding between back-to-back loads, and register contents after the writes.

// File: rtl/hwld_pkg.sv
`timescale 1ns/1ps
package hwld_pkg;
  localparam int XLEN   = 24;
  localparam int HALF_W = 16;
  localparam int IMM_W  = 13;
  localparam int HI_W   = XLEN - IMM_W;

  function automatic logic is_load(input logic [15:0] w);
    return (w[15:10] == 6'b001000) && (w[6:3] == 4'b0010);
  endfunction

  function automatic logic is_prefix(input logic [15:0] w);
    return w[15:13] == 3'b110;
  endfunction

  function automatic logic [XLEN-1:0] disp_build(input logic [1:0] cnt,
                                                 input logic [IMM_W-1:0] older,
                                                 input logic [IMM_W-1:0] newer);
    logic [XLEN-1:0] d;
    case (cnt)
      2'd1:    d = {{HI_W{1'b0}}, newer};
      2'd2:    d = {older[HI_W-1:0], newer};
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [XLEN-1:0] ea_build(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] disp);
    return base + disp;
  endfunction

  function automatic logic [XLEN-1:0] half_align(input logic [XLEN-1:0] ea);
    return {ea[XLEN-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/hwld_prefix.sv
`timescale 1ns/1ps
module hwld_prefix
  import hwld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  input  logic [15:0]      word,
  output logic [1:0]       cnt,
  output logic [IMM_W-1:0] older,
  output logic [IMM_W-1:0] newer
);
  logic take_pfx;
  logic drop_pfx;

  assign take_pfx = word_vld && is_prefix(word);
  assign drop_pfx = word_vld && !is_prefix(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      older <= '0;
      newer <= '0;
    end else if (take_pfx) begin
      older <= newer;
      newer <= word[IMM_W-1:0];
      cnt   <= (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;
    end else if (drop_pfx) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/hwld_regfile.sv
`timescale 1ns/1ps
module hwld_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 24,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (waddr == AW'(g)))
        regs[g] <= wdata;
    end
  end

  // port A forwards the write in flight so back-to-back loads see it
  assign rdata_a = (we && (waddr == raddr_a)) ? wdata : regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/hwld_agen.sv
`timescale 1ns/1ps
module hwld_agen
  import hwld_pkg::*;
(
  input  logic [XLEN-1:0]  base,
  input  logic [1:0]       pfx_cnt,
  input  logic [IMM_W-1:0] pfx_older,
  input  logic [IMM_W-1:0] pfx_newer,
  input  logic             in_slot,
  output logic [XLEN-1:0]  rd_addr,
  output logic             odd
);
  logic [1:0]      eff_cnt;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] ea;

  assign eff_cnt = in_slot ? 2'd0 : pfx_cnt;
  assign disp    = disp_build(eff_cnt, pfx_older, pfx_newer);
  assign ea      = ea_build(base, disp);
  assign odd     = ea[0];
  assign rd_addr = half_align(ea);
endmodule

// File: rtl/hwld_unit.sv
`timescale 1ns/1ps
module hwld_unit
  import hwld_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_vld,
  input  logic [15:0]       issue_word,
  input  logic              issue_in_slot,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_rd_addr,
  input  logic [HALF_W-1:0] mem_rd_data,
  output logic              misalign_pulse,
  input  logic [RW-1:0]     obs_sel,
  output logic [XLEN-1:0]   obs_data
);
  logic             dec_load;
  logic [RW-1:0]    rd_idx;
  logic [RW-1:0]    rb_idx;
  logic [XLEN-1:0]  base_val;
  logic [1:0]       pfx_cnt;
  logic [IMM_W-1:0] pfx_older;
  logic [IMM_W-1:0] pfx_newer;
  logic             ea_odd;
  logic             wb_en;
  logic [RW-1:0]    wb_idx;
  logic [XLEN-1:0]  wb_data;
  logic             mis_q;

  assign dec_load = issue_vld && is_load(issue_word);
  assign rd_idx   = issue_word[7 +: RW];
  assign rb_idx   = issue_word[0 +: RW];

  hwld_prefix i_prefix (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (issue_vld),
    .word     (issue_word),
    .cnt      (pfx_cnt),
    .older    (pfx_older),
    .newer    (pfx_newer)
  );

  hwld_regfile #(.NREG(NREG), .DW(XLEN)) i_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_en),
    .waddr   (wb_idx),
    .wdata   (wb_data),
    .raddr_a (rb_idx),
    .rdata_a (base_val),
    .raddr_b (obs_sel),
    .rdata_b (obs_data)
  );

  hwld_agen i_agen (
    .base      (base_val),
    .pfx_cnt   (pfx_cnt),
    .pfx_older (pfx_older),
    .pfx_newer (pfx_newer),
    .in_slot   (issue_in_slot),
    .rd_addr   (mem_rd_addr),
    .odd       (ea_odd)
  );

  assign mem_rd_en = dec_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en  <= 1'b0;
      wb_idx <= '0;
      mis_q  <= 1'b0;
    end else begin
      wb_en  <= dec_load;
      wb_idx <= rd_idx;
      mis_q  <= dec_load && ea_odd;
    end
  end

  assign wb_data        = {{(XLEN-HALF_W){1'b0}}, mem_rd_data};
  assign misalign_pulse = mis_q;
endmodule

// File: rtl/hwld_checker.sv
`timescale 1ns/1ps
module hwld_checker
  import hwld_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            issue_vld,
  input logic [15:0]     issue_word,
  input logic            issue_in_slot,
  input logic            mem_rd_en,
  input logic [XLEN-1:0] mem_rd_addr,
  input logic            misalign_pulse,
  input logic [2:0]      obs_sel,
  input logic [XLEN-1:0] obs_data,
  input logic            wb_en,
  input logic [2:0]      wb_idx,
  input logic [XLEN-1:0] base_val,
  input logic [1:0]      pfx_cnt
);
  p_addr_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[0] == 1'b0));

  p_mis_with_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_pulse |-> wb_en);

  p_wb_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> wb_en);

  p_no_stray_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> !wb_en);

  p_slot_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && issue_in_slot) |-> (mem_rd_addr == {base_val[XLEN-1:1], 1'b0}));

  p_pfx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (issue_word[15:13] != 3'b110)) |=> (pfx_cnt == 2'd0));

  p_pfx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(pfx_cnt));

  p_pfx_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt <= 2'd2);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wb_en) && (obs_sel == $past(wb_idx))) |-> (obs_data[XLEN-1:HALF_W] == '0));
endmodule

bind hwld_unit hwld_checker i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue_vld      (issue_vld),
  .issue_word     (issue_word),
  .issue_in_slot  (issue_in_slot),
  .mem_rd_en      (mem_rd_en),
  .mem_rd_addr    (mem_rd_addr),
  .misalign_pulse (misalign_pulse),
  .obs_sel        (obs_sel),
  .obs_data       (obs_data),
  .wb_en          (wb_en),
  .wb_idx         (wb_idx),
  .base_val       (base_val),
  .pfx_cnt        (pfx_cnt)
);

// File: tb/test_hwld_unit.sv
`timescale 1ns/1ps
module test_hwld_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_vld = 1'b0;
  logic [15:0] issue_word = '0;
  logic        issue_in_slot = 1'b0;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        misalign_pulse;
  logic [2:0]  obs_sel = '0;
  logic [23:0] obs_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hwld_unit i_hwld_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_vld      (issue_vld),
    .issue_word     (issue_word),
    .issue_in_slot  (issue_in_slot),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_data    (mem_rd_data),
    .misalign_pulse (misalign_pulse),
    .obs_sel        (obs_sel),
    .obs_data       (obs_data)
  );

  function automatic logic [15:0] memf(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
  endfunction

  // synchronous memory: data appears the cycle after the request
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  function automatic logic [15:0] ldw(input int rd, input int rb);
    return 16'h2010 | 16'(rd << 7) | 16'(rb);
  endfunction

  function automatic logic [15:0] pxw(input int imm);
    return 16'hC000 | 16'(imm & 16'h1FFF);
  endfunction

  localparam int NV = 27;
  // {vld, slot, word}
  localparam logic [17:0] VEC [NV] = '{
    {2'b10, ldw(1, 0)},
    {2'b10, pxw(16'h0123)},            // R4 odd result
    {2'b10, ldw(2, 0)},
    {2'b10, pxw(16'h07FF)},
    {2'b10, pxw(16'h1FFF)},
    {2'b10, ldw(3, 1)},                // R5 wraps past 2^24
    {2'b10, ldw(4, 3)},                // R10 forward from previous load
    {2'b10, pxw(5)},
    {2'b10, 16'h0000},                 // R9 other word drops prefix
    {2'b10, ldw(5, 4)},
    {2'b10, pxw(1)},
    {2'b10, pxw(2)},
    {2'b10, pxw(3)},                   // R9 third prefix displaces oldest
    {2'b10, ldw(6, 0)},
    {2'b10, pxw(16'h0010)},
    {2'b11, ldw(7, 1)},                // R8 slot load ignores prefix
    {2'b10, ldw(2, 2)},                // R6 base equals destination
    {2'b10, pxw(16'h0444)},
    {2'b00, ldw(1, 5)},                // R1 issue_vld low: no read, R9 hold
    {2'b10, ldw(1, 5)},
    {2'b10, pxw(16'h0020)},
    {2'b10, ldw(3, 0) ^ 16'h0008},     // R1 bits 6:3 = 0011, not a load
    {2'b10, ldw(3, 0)},
    {2'b10, pxw(1)},
    {2'b10, pxw(0)},
    {2'b10, ldw(0, 0)},
    {2'b10, ldw(3, 0)}
  };

  logic [23:0] mdl [8];
  int          pn = 0;
  logic [12:0] pq_old = '0, pq_new = '0;
  logic        exp_mis = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [15:0] w);
    logic [23:0] disp, ea;
    logic        ld;
    string       tg;
    @(negedge clk);
    chk("R7 misalign pulse", 32'(misalign_pulse), 32'(exp_mis));
    issue_vld = v; issue_in_slot = s; issue_word = w;
    #1;
    ld = v && (w[15:10] == 6'b001000) && (w[6:3] == 4'b0010);
    chk("R1/R10 read enable", 32'(mem_rd_en), 32'(ld));
    exp_mis = 1'b0;
    if (ld) begin
      if (s || pn == 0) disp = 24'h0;
      else if (pn == 1) disp = 24'(pq_new);
      else disp = (24'(pq_old & 13'h7FF) << 13) + 24'(pq_new);
      tg = s ? "R8 slot address" : (pn == 0 ? "R3 plain address" :
           (pn == 1 ? "R4 short disp address" : "R5 long disp address"));
      ea = mdl[w[2:0]] + disp;
      chk(tg, 32'(mem_rd_addr), 32'(ea & 24'hFFFFFE));
      exp_mis = ea[0];
      mdl[w[9:7]] = {8'h00, memf(ea & 24'hFFFFFE)};
    end
    if (v) begin
      if (w[15:13] == 3'b110) begin
        pq_old = pq_new; pq_new = w[12:0];
        if (pn < 2) pn++;
      end else pn = 0;
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) begin
      obs_sel = 3'(i);
      #0.2;
      chk(tag, 32'(obs_data), 32'(mdl[i]));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk); #1;
    chk("R11 no pulse after reset", 32'(misalign_pulse), 32'h0);
    chk("R11 no read after reset", 32'(mem_rd_en), 32'h0);
    sweep("R11 registers zero");

    for (int k = 0; k < NV; k++)
      step(VEC[k][17], VEC[k][16], VEC[k][15:0]);
    step(1'b0, 1'b0, 16'h0);
    step(1'b0, 1'b0, 16'h0);
    @(negedge clk); #1;
    sweep("R2/R6 register contents");

    // R11 reset drops pending prefix and registers
    step(1'b1, 1'b0, pxw(16'h0055));
    @(negedge clk);
    issue_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 pulse cleared in reset", 32'(misalign_pulse), 32'h0);
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    pn = 0; exp_mis = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    sweep("R11 registers zero again");
    step(1'b1, 1'b0, ldw(1, 0));      // R11 prefix gone: plain address 0
    step(1'b0, 1'b0, 16'h0);
    @(negedge clk); #1;
    sweep("R2 after reset load");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule